// File: doc/BRIEF.md
# Programmable Free-Running Clock Divider

This block makes two free-running clocks from one fast input clock. The bus rate is half the fast clock. One output is a divided clock. Its period is a programmable number N of bus cycles, and an optional divide-by-16 stage can stretch that period further. The other output is a companion clock that runs at the full fast-clock rate. An 8-bit control register sets both outputs, and a separate reserved register always reads zero.

Both outputs can be switched off independently, and a switched-off output sits at logic 0. The divided clock never shows a runt pulse. A new ratio waits for the end of the current output period. Re-enabling the divided clock starts it again at the beginning of a high phase. The companion clock is gated by a latch that is transparent while the fast clock is low, so it can only be switched on or off between its pulses.

The register port is a single-cycle write strobe with a one-bit address. Address 0 is the control register and address 1 is the reserved register. Read data is a combinational function of the address.

Top module: `eck_clkgen`

## Requirements
- R1: After reset, the control register (address 0) reads 0x00, the divided clock toggles on every fast-clock edge (bus rate), and the companion clock follows the input clock.
- R2: A write to address 0 stores all eight bits, and a read of address 0 returns them unchanged.
- R3: Address 1 always reads 0x00, and a write to address 1 leaves the control register unchanged.
- R4: With bit 5 clear, the divided clock period is 2·N fast cycles, where N = bits[4:0] + 1 (1 to 32).
- R5: With bit 5 set, N becomes (bits[4:0] + 1) · 16, so the period is 2·N fast cycles.
- R6: Duty cycle, in fast cycles per period. For even N the output is high for N cycles. For odd N ≥ 3 it is high for 2·floor(N/2) cycles. For N = 1 it is high for 1 cycle and low for 1 cycle.
- R7: While bit 7 is 1, the divided clock is held at 0 from the second fast edge after the write.
- R8: When bit 7 returns to 0, the divided clock goes high on the second fast edge after the write and starts a new period from its high phase.
- R9: A ratio written in mid-period does not change the period in progress. The new ratio applies from the next period boundary.
- R10: While bit 6 is 1, the companion clock stays at 0. While bit 6 is 0, the companion clock equals the fast input clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Fast input clock; the bus rate is half of it |
| i_rst | input | 1 | Synchronous active-high reset |
| i_wr_en | input | 1 | Register write strobe, one cycle per write |
| i_addr | input | 1 | Register select: 0 control, 1 reserved |
| i_wdata | input | 8 | Write data |
| o_rdata | output | 8 | Read data for the selected register |
| o_div_clk | output | 1 | Divided free-running clock |
| o_fast_clk | output | 1 | Gated companion clock at the fast-clock rate |

## Verification
The assertions assume the inputs are sampled at the rising edge of the fast clock and that the write strobe is a clean single-cycle pulse. They also assume the fast clock has no glitches, because the companion gate latch depends on a stable low phase. The bench changes every input only at falling edges and pulses the strobe for exactly one cycle. It samples the divided clock at falling edges and the companion clock in the middle of each clock phase, so no check depends on the order of events at an edge. The sweep covers every ratio field value, both with and without the prescaler.

// File: rtl/eck_pkg.sv
package eck_pkg;

    // Width of the ratio field and log2 of the prescale factor
    localparam int RATIO_W   = 5;
    localparam int PRE_LOG2  = 4;
    // Fast-cycle counter: N up to 2^(RATIO_W+PRE_LOG2), period 2N
    localparam int CNT_W     = RATIO_W + PRE_LOG2 + 1;
    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_RSVD = 1'b1;

    typedef struct packed {
        logic               div_off;   // bit 7
        logic               fast_off;  // bit 6
        logic               pre16;     // bit 5
        logic [RATIO_W-1:0] ratio;     // bits 4..0
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0] last;  // period length in fast cycles minus one
        logic [CNT_W-1:0] high;  // fast cycles spent high per period
    } timing_t;

    function automatic timing_t calc_timing(ctrl_t c);
        timing_t          t;
        logic [CNT_W-1:0] n;
        n = CNT_W'(c.ratio) + CNT_W'(1);
        if (c.pre16)
            n = n << PRE_LOG2;
        t.last = (n << 1) - CNT_W'(1);
        if (n == CNT_W'(1))
            t.high = CNT_W'(1);
        else
            t.high = n & ~CNT_W'(1);
        return t;
    endfunction

endpackage

// File: rtl/eck_regs.sv
module eck_regs
    import eck_pkg::*;
(
    input  logic        i_clk,
    input  logic        i_rst,
    input  logic        i_wr_en,
    input  logic        i_addr,
    input  logic [7:0]  i_wdata,
    output logic [7:0]  o_rdata,
    output ctrl_t       o_ctrl
);

    ctrl_t ctrl_q;

    always_ff @(posedge i_clk) begin
        if (i_rst)
            ctrl_q <= '0;
        else if (i_wr_en && i_addr == ADDR_CTRL)
            ctrl_q <= ctrl_t'(i_wdata);
    end

    always_comb begin
        o_rdata = 8'h00;
        if (i_addr == ADDR_CTRL)
            o_rdata = ctrl_q;
    end

    assign o_ctrl = ctrl_q;

    AST_CTRL_STORED: assert property (@(posedge i_clk) disable iff (i_rst)
        (i_wr_en && i_addr == ADDR_CTRL) |=> (o_ctrl == ctrl_t'($past(i_wdata)))); // R2

    AST_RSVD_NO_EFFECT: assert property (@(posedge i_clk) disable iff (i_rst)
        (!i_wr_en || i_addr == ADDR_RSVD) |=> $stable(o_ctrl)); // R3

endmodule

// File: rtl/eck_divider.sv
module eck_divider
    import eck_pkg::*;
(
    input  logic  i_clk,
    input  logic  i_rst,
    input  ctrl_t i_ctrl,
    output logic  o_div_clk
);

    logic [CNT_W-1:0] cnt_q;
    timing_t          act_q;
    timing_t          next_t;
    logic             wrap;
    logic             out_q;

    assign next_t = calc_timing(i_ctrl);
    assign wrap   = (cnt_q == act_q.last);

    always_ff @(posedge i_clk) begin
        if (i_rst) begin
            cnt_q <= '0;
            act_q <= calc_timing('0);
            out_q <= 1'b0;
        end else if (i_ctrl.div_off) begin
            cnt_q <= '0;
            act_q <= next_t;
            out_q <= 1'b0;
        end else begin
            out_q <= (cnt_q < act_q.high);
            if (wrap) begin
                cnt_q <= '0;
                act_q <= next_t;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign o_div_clk = out_q;

    AST_CNT_IN_RANGE: assert property (@(posedge i_clk) disable iff (i_rst)
        cnt_q <= act_q.last); // R4

    AST_HIGH_WITHIN_PERIOD: assert property (@(posedge i_clk) disable iff (i_rst)
        (act_q.high != '0) && (act_q.high <= act_q.last)); // R6

    AST_RATIO_HELD_MIDPERIOD: assert property (@(posedge i_clk) disable iff (i_rst)
        (!i_ctrl.div_off && cnt_q != act_q.last) |=> $stable(act_q)); // R9

    AST_OFF_IS_LOW: assert property (@(posedge i_clk) disable iff (i_rst)
        i_ctrl.div_off |=> !o_div_clk); // R7

    AST_RESTART_HIGH: assert property (@(posedge i_clk) disable iff (i_rst)
        (cnt_q == '0 && !i_ctrl.div_off) |=> o_div_clk); // R8

endmodule

// File: rtl/eck_fastgate.sv
module eck_fastgate (
    input  logic i_clk,
    input  logic i_off,
    output logic o_fast_clk
);

    logic en_lat;

    // Gate enable is transparent only while the clock is low
    always_latch begin
        if (!i_clk)
            en_lat = !i_off;
    end

    assign o_fast_clk = i_clk & en_lat;

endmodule

// File: rtl/eck_clkgen.sv
module eck_clkgen
    import eck_pkg::*;
(
    input  logic       i_clk,
    input  logic       i_rst,
    input  logic       i_wr_en,
    input  logic       i_addr,
    input  logic [7:0] i_wdata,
    output logic [7:0] o_rdata,
    output logic       o_div_clk,
    output logic       o_fast_clk
);

    ctrl_t ctrl;

    eck_regs i_regs (
        .i_clk   (i_clk),
        .i_rst   (i_rst),
        .i_wr_en (i_wr_en),
        .i_addr  (i_addr),
        .i_wdata (i_wdata),
        .o_rdata (o_rdata),
        .o_ctrl  (ctrl)
    );

    eck_divider i_divider (
        .i_clk     (i_clk),
        .i_rst     (i_rst),
        .i_ctrl    (ctrl),
        .o_div_clk (o_div_clk)
    );

    eck_fastgate i_fastgate (
        .i_clk      (i_clk),
        .i_off      (ctrl.fast_off),
        .o_fast_clk (o_fast_clk)
    );

    AST_RSVD_READS_ZERO: assert property (@(posedge i_clk) disable iff (i_rst)
        (i_addr == ADDR_RSVD) |-> (o_rdata == 8'h00)); // R3

endmodule

// File: tb/test_eck_clkgen.sv
module test_eck_clkgen;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic       addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       div_clk;
    logic       fast_clk;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    eck_clkgen i_eck_clkgen (
        .i_clk      (clk),
        .i_rst      (rst),
        .i_wr_en    (wr_en),
        .i_addr     (addr),
        .i_wdata    (wdata),
        .o_rdata    (rdata),
        .o_div_clk  (div_clk),
        .o_fast_clk (fast_clk)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 1'b0;
    endtask

    function automatic int ratio_n(input int pre, input int field);
        return (field + 1) * (pre != 0 ? 16 : 1);
    endfunction

    function automatic int high_len(input int n);
        if (n == 1) return 1;
        return 2 * (n / 2);
    endfunction

    // Disable then enable with a given setting; compare a few whole periods
    task automatic run_cfg(input int pre, input int field, input int periods, input string req);
        int n, h, p, bad_j, bad_v;
        n = ratio_n(pre, field);
        h = high_len(n);
        p = 2 * n;
        bad_j = -1; bad_v = 0;
        write_reg(1'b0, 8'h80 | 8'(pre << 5) | 8'(field));
        write_reg(1'b0, 8'(pre << 5) | 8'(field));
        for (int j = 0; j < p * periods; j++) begin
            @(negedge clk);
            if (bad_j < 0 && int'(div_clk) != int'((j % p) < h)) begin
                bad_j = j; bad_v = int'(div_clk);
            end
        end
        checks++;
        if (bad_j >= 0) begin
            errors++;
            $display("FAIL %s pre=%0d field=%0d sample %0d: actual %0d expected %0d",
                     req, pre, field, bad_j, bad_v, int'((bad_j % p) < h));
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; addr = 1'b0; wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        #1 check("R1", int'(rdata), 0, "ctrl after reset");
        addr = 1'b1;
        #1 check("R3", int'(rdata), 0, "reserved after reset");
        addr = 1'b0;
        begin
            int bad = 0;
            int prev;
            @(negedge clk);
            prev = int'(div_clk);
            for (int j = 0; j < 16; j++) begin
                @(negedge clk);
                if (int'(div_clk) == prev) bad++;
                prev = int'(div_clk);
            end
            check("R1", bad, 0, "bus-rate toggle misses after reset");
        end
        begin
            int bad = 0;
            for (int j = 0; j < 8; j++) begin
                @(posedge clk); #2;
                if (fast_clk !== 1'b1) bad++;
                @(negedge clk); #2;
                if (fast_clk !== 1'b0) bad++;
            end
            check("R1", bad, 0, "companion mismatches after reset");
        end

        // R2: read back of every control value
        begin
            int bad = 0;
            for (int v = 0; v < 256; v++) begin
                write_reg(1'b0, 8'(v));
                #1;
                if (int'(rdata) != v) begin
                    bad++;
                    if (bad == 1)
                        $display("FAIL R2 readback: actual %0d expected %0d", rdata, v);
                end
            end
            checks++;
            if (bad != 0) errors++;
        end

        // R3: reserved address ignores writes
        write_reg(1'b0, 8'h5A);
        write_reg(1'b1, 8'hFF);
        addr = 1'b1;
        #1 check("R3", int'(rdata), 0, "reserved read after write");
        addr = 1'b0;
        #1 check("R3", int'(rdata), 8'h5A, "ctrl after reserved write");

        // R4, R6: every field without prescale
        for (int f = 0; f < 32; f++)
            run_cfg(0, f, 2, "R4/R6");

        // R5: every field with prescale
        for (int f = 0; f < 32; f++)
            run_cfg(1, f, 1, "R5");

        // R7: disabled output held low
        write_reg(1'b0, 8'h83);
        begin
            int bad = 0;
            for (int j = 0; j < 24; j++) begin
                @(negedge clk);
                if (div_clk !== 1'b0) bad++;
            end
            check("R7", bad, 0, "high samples while disabled");
        end

        // R8: restart on re-enable goes high on the second edge
        write_reg(1'b0, 8'h03);
        @(negedge clk);
        check("R8", int'(div_clk), 1, "first sample after enable");

        // R9: ratio change in mid-period
        write_reg(1'b0, 8'h83);
        write_reg(1'b0, 8'h03);
        begin
            int bad = 0, bad_j = -1, bad_v = 0, exp;
            for (int j = 0; j < 24; j++) begin
                @(negedge clk);
                if (j < 8) exp = int'(j < 4);
                else       exp = int'(((j - 8) % 4) < 2);
                if (int'(div_clk) != exp && bad_j < 0) begin
                    bad_j = j; bad_v = int'(div_clk);
                end
                if (j == 2) begin
                    wr_en = 1'b1; addr = 1'b0; wdata = 8'h01;
                end
                if (j == 3) wr_en = 1'b0;
            end
            if (bad_j >= 0) begin
                bad = 1;
                $display("FAIL R9 sample %0d: actual %0d expected %0d", bad_j, bad_v,
                         bad_j < 8 ? int'(bad_j < 4) : int'(((bad_j - 8) % 4) < 2));
            end
            checks++;
            if (bad != 0) errors++;
        end

        // R10: companion gating
        write_reg(1'b0, 8'h40);
        @(negedge clk);
        begin
            int bad = 0;
            for (int j = 0; j < 8; j++) begin
                @(posedge clk); #2;
                if (fast_clk !== 1'b0) bad++;
            end
            check("R10", bad, 0, "companion high while off");
        end
        write_reg(1'b0, 8'h00);
        @(negedge clk);
        begin
            int bad = 0;
            for (int j = 0; j < 8; j++) begin
                @(posedge clk); #2;
                if (fast_clk !== 1'b1) bad++;
                @(negedge clk); #2;
                if (fast_clk !== 1'b0) bad++;
            end
            check("R10", bad, 0, "companion mismatch when re-enabled");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule